// File: doc/BRIEF.md
# 16-bit Address Arithmetic Unit

This block performs the 16-bit arithmetic that an 8-bit processor core needs for its register pairs, stack pointer and program counter. Each request carries an operation code, one or two 16-bit operands, a signed 8-bit displacement and the current four condition flags. One clock later the unit returns the 16-bit result and the updated flags. Register storage, bus sequencing and branch condition tests belong to the surrounding core.

The operations are: adding a register pair to the HL pair; incrementing or decrementing a pair; adding a signed displacement to the stack pointer, with the sum sent either back to the stack pointer or to HL; offsetting the program counter by a signed displacement; and moving the stack pointer down by two before a push or up by two after a pop. Each operation has its own flag rule. The displacement forms take half-carry and carry from the low byte only.

Top module: `addr_alu_top`

## Requirements
- R1: A request presented with `in_valid` high on a rising edge produces `out_valid` high after that edge. With `in_valid` low, `out_valid` is low after the edge.
- R2: Operation code 0 (pair add) returns `in_a + in_b` modulo 65536. It keeps zero (flag bit 3) from `in_flags`, clears subtract (bit 2), sets half-carry (bit 1) to the carry out of bit 11, and sets carry (bit 0) to the carry out of bit 15.
- R3: Operation code 1 returns `in_a + 1` and code 2 returns `in_a - 1`, both modulo 65536. The flags are `in_flags` unchanged.
- R4: Operation codes 3 and 4 return `in_a` plus `in_disp` sign-extended to 16 bits, modulo 65536. `out_to_hl` is 1 for code 4 and 0 for every other code.
- R5: For codes 3 and 4, zero (bit 3) and subtract (bit 2) are 0. Half-carry (bit 1) is the carry out of bit 3 and carry (bit 0) is the carry out of bit 7 of the unsigned sum `in_a[7:0] + in_disp`.
- R6: Operation code 5 (relative program-counter offset) returns `in_a` plus the sign-extended `in_disp`, modulo 65536, and leaves the flags unchanged.
- R7: Operation code 6 returns `in_a - 2` (push adjust) and code 7 returns `in_a + 2` (pop adjust), modulo 65536. The flags are unchanged.
- R8: While `rst_n` is low, `out_valid`, `out_result`, `out_flags` and `out_to_hl` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code |
| in_a | input | 16 | Primary operand (pair, SP or PC) |
| in_b | input | 16 | Second pair for the pair add |
| in_disp | input | 8 | Signed displacement |
| in_flags | input | 4 | Current flags {z,n,h,c} |
| out_valid | output | 1 | Result strobe |
| out_result | output | 16 | 16-bit result |
| out_flags | output | 4 | New flags {z,n,h,c} |
| out_to_hl | output | 1 | Displacement sum goes to HL |

## Verification
The pair add is driven with operands that carry only out of bit 11, only out of bit 15, out of both, and out of neither. A wrap to zero with the incoming zero flag clear shows that zero is kept and not recomputed. The displacement forms use negative, positive and 0x80 displacements on stack pointers whose low byte does or does not carry. This separates low-byte flag rules from full-width ones, and a zero result shows that zero is forced clear. Increment, decrement and the push/pop adjusts are run across the 0x0000/0xFFFF boundary with non-trivial incoming flags, and requests are sent both back-to-back and with idle gaps.

// File: rtl/addr_alu_pkg.sv
package addr_alu_pkg;

  localparam int FLAG_W = 4;
  localparam int FLAG_Z = 3;
  localparam int FLAG_N = 2;
  localparam int FLAG_H = 1;
  localparam int FLAG_C = 0;

  typedef enum logic [2:0] {
    OP_PAIR_ADD  = 3'd0,
    OP_INC       = 3'd1,
    OP_DEC       = 3'd2,
    OP_SP_DISP   = 3'd3,
    OP_SP_TO_HL  = 3'd4,
    OP_PC_REL    = 3'd5,
    OP_PUSH_ADJ  = 3'd6,
    OP_POP_ADJ   = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } alu_flags_t;

  // Flag rule for the pair add: zero passes through, subtract clears.
  function automatic alu_flags_t pair_add_flags(alu_flags_t old_f, logic half, logic carry);
    alu_flags_t f;
    f.z = old_f.z;
    f.n = 1'b0;
    f.h = half;
    f.c = carry;
    return f;
  endfunction

  // Flag rule for the displacement forms: zero and subtract forced low.
  function automatic alu_flags_t disp_flags(logic half, logic carry);
    alu_flags_t f;
    f.z = 1'b0;
    f.n = 1'b0;
    f.h = half;
    f.c = carry;
    return f;
  endfunction

  function automatic logic is_disp_op(alu_op_e op);
    return (op == OP_SP_DISP) || (op == OP_SP_TO_HL);
  endfunction

  function automatic logic is_step_op(alu_op_e op);
    return (op == OP_INC) || (op == OP_DEC) ||
           (op == OP_PUSH_ADJ) || (op == OP_POP_ADJ);
  endfunction

endpackage

// File: rtl/addr_alu_seg_add.sv
// Two-segment adder: exposes the carry out of the low segment and of the
// full width as named wires, so no wide carry vector is left partly unused.
module addr_alu_seg_add #(
  parameter int W    = 16,
  parameter int LO_W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         seg_carry,
  output logic         top_carry
);
  localparam int HI_W = W - LO_W;

  logic [LO_W:0] lo_sum;
  logic [HI_W:0] hi_sum;

  assign lo_sum    = {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]};
  assign seg_carry = lo_sum[LO_W];
  assign hi_sum    = {1'b0, a[W-1:LO_W]} + {1'b0, b[W-1:LO_W]}
                   + {{HI_W{1'b0}}, seg_carry};
  assign top_carry = hi_sum[HI_W];
  assign sum       = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};

  initial begin
    seg_split_ok: assert (LO_W > 0 && LO_W < W)
      else $error("segment cut outside operand");
  end
endmodule

// File: rtl/addr_alu_step.sv
// Fixed-step adjust: +1, -1, +2, -2 selected by two control bits.
module addr_alu_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic         down,
  input  logic         by_two,
  output logic [W-1:0] result
);
  logic [W-1:0] delta;

  assign delta  = {{(W-2){1'b0}}, by_two, ~by_two};
  assign result = down ? (a - delta) : (a + delta);
endmodule

// File: rtl/addr_alu_disp_add.sv
// Base plus sign-extended displacement, with flags from the low byte only.
module addr_alu_disp_add #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] sum,
  output logic              low_half_carry,
  output logic              low_carry
);
  localparam int UP_W  = ADDR_W - DISP_W;
  localparam int NIB_W = DISP_W / 2;

  logic [DISP_W-1:0] low_sum;
  logic [UP_W-1:0]   up_sum;
  logic [UP_W-1:0]   ext_hi;

  addr_alu_seg_add #(.W(DISP_W), .LO_W(NIB_W)) u_low (
    .a         (base[DISP_W-1:0]),
    .b         (disp),
    .sum       (low_sum),
    .seg_carry (low_half_carry),
    .top_carry (low_carry)
  );

  assign ext_hi = {UP_W{disp[DISP_W-1]}};
  assign up_sum = base[ADDR_W-1:DISP_W] + ext_hi + {{(UP_W-1){1'b0}}, low_carry};
  assign sum    = {up_sum, low_sum};
endmodule

// File: rtl/addr_alu_top.sv
module addr_alu_top #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [ADDR_W-1:0] in_a,
  input  logic [ADDR_W-1:0] in_b,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [3:0]        in_flags,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_result,
  output logic [3:0]        out_flags,
  output logic              out_to_hl
);
  import addr_alu_pkg::*;

  localparam int PAIR_HALF_W = ADDR_W - 4;

  alu_op_e    op;
  alu_flags_t flags_old;

  assign op        = alu_op_e'(in_op);
  assign flags_old = alu_flags_t'(in_flags);

  // Pair add path
  logic [ADDR_W-1:0] pair_sum;
  logic              pair_half_w;
  logic              pair_carry_w;

  addr_alu_seg_add #(.W(ADDR_W), .LO_W(PAIR_HALF_W)) u_pair (
    .a         (in_a),
    .b         (in_b),
    .sum       (pair_sum),
    .seg_carry (pair_half_w),
    .top_carry (pair_carry_w)
  );

  // Displacement path (SP forms and PC offset)
  logic [ADDR_W-1:0] disp_sum;
  logic              disp_half_w;
  logic              disp_carry_w;

  addr_alu_disp_add #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_disp (
    .base           (in_a),
    .disp           (in_disp),
    .sum            (disp_sum),
    .low_half_carry (disp_half_w),
    .low_carry      (disp_carry_w)
  );

  // Fixed-step path
  logic [ADDR_W-1:0] step_sum;
  logic              step_down;
  logic              step_two;

  assign step_down = (op == OP_DEC) || (op == OP_PUSH_ADJ);
  assign step_two  = (op == OP_PUSH_ADJ) || (op == OP_POP_ADJ);

  addr_alu_step #(.W(ADDR_W)) u_step (
    .a      (in_a),
    .down   (step_down),
    .by_two (step_two),
    .result (step_sum)
  );

  // Result and flag selection
  logic [ADDR_W-1:0] nxt_result;
  alu_flags_t        nxt_flags;

  always_comb begin
    nxt_result = step_sum;
    nxt_flags  = flags_old;
    if (op == OP_PAIR_ADD) begin
      nxt_result = pair_sum;
      nxt_flags  = pair_add_flags(flags_old, pair_half_w, pair_carry_w);
    end else if (is_disp_op(op)) begin
      nxt_result = disp_sum;
      nxt_flags  = disp_flags(disp_half_w, disp_carry_w);
    end else if (op == OP_PC_REL) begin
      nxt_result = disp_sum;
    end
  end

  // Output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
      out_to_hl  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= nxt_result;
        out_flags  <= nxt_flags;
        out_to_hl  <= (op == OP_SP_TO_HL);
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2
  pair_zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_PAIR_ADD) |=>
      (out_flags[FLAG_Z] == $past(in_flags[FLAG_Z])) && !out_flags[FLAG_N]);

  // R2
  pair_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_PAIR_ADD) |=>
      (out_flags[FLAG_C] == (out_result < $past(in_a))) &&
      (out_flags[FLAG_H] == (out_result[PAIR_HALF_W-1:0] < $past(in_a[PAIR_HALF_W-1:0]))));

  // R3
  step_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_step_op(op)) |=> (out_flags == $past(in_flags)));

  // R4
  disp_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_to_hl == ($past(in_op) == 3'd4)));

  // R5
  disp_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_disp_op(op)) |=>
      !out_flags[FLAG_Z] && !out_flags[FLAG_N] &&
      (out_flags[FLAG_C] == (out_result[DISP_W-1:0] < $past(in_a[DISP_W-1:0]))));

  // R6
  pc_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_PC_REL) |=> (out_flags == $past(in_flags)));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> !out_valid && (out_result == '0) && (out_flags == '0));
endmodule

// File: tb/tb_addr_alu_top.sv
module tb_addr_alu_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [15:0] in_a = '0;
  logic [15:0] in_b = '0;
  logic [7:0]  in_disp = '0;
  logic [3:0]  in_flags = '0;
  logic        out_valid;
  logic [15:0] out_result;
  logic [3:0]  out_flags;
  logic        out_to_hl;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [15:0] res;
    logic [3:0]  flg;
    logic        hl;
    string       req;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_alu_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_disp(in_disp), .in_flags(in_flags),
    .out_valid(out_valid), .out_result(out_result),
    .out_flags(out_flags), .out_to_hl(out_to_hl)
  );

  // Reference model written from the requirements
  function automatic exp_t model(logic [2:0] op, logic [15:0] a, logic [15:0] b,
                                 logic [7:0] d, logic [3:0] f, string req);
    exp_t e;
    int   sa, sd, tot;
    e.flg = f;
    e.hl  = (op == 3'd4);
    e.req = req;
    sd = (d >= 8'h80) ? int'(d) - 256 : int'(d);
    case (op)
      3'd0: begin
        tot   = int'(a) + int'(b);
        e.res = tot[15:0];
        e.flg = {f[3], 1'b0,
                 ((int'(a) % 4096) + (int'(b) % 4096)) >= 4096,
                 tot >= 65536};
      end
      3'd1: e.res = a + 16'd1;
      3'd2: e.res = a - 16'd1;
      3'd3, 3'd4: begin
        sa    = int'(a) + sd;
        e.res = sa[15:0];
        e.flg = {1'b0, 1'b0,
                 ((int'(a) % 16) + (int'(d) % 16)) >= 16,
                 ((int'(a) % 256) + int'(d)) >= 256};
      end
      3'd5: begin
        sa    = int'(a) + sd;
        e.res = sa[15:0];
      end
      3'd6: e.res = a - 16'd2;
      default: e.res = a + 16'd2;
    endcase
    return e;
  endfunction

  task automatic send(logic [2:0] op, logic [15:0] a, logic [15:0] b,
                      logic [7:0] d, logic [3:0] f, string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    in_a     = a;
    in_b     = b;
    in_disp  = d;
    in_flags = f;
    sb.push_back(model(op, a, b, d, f, req));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_a     = 16'hDEAD;
      in_op    = 3'd0;
    end
  endtask

  // Monitor: pops and compares whenever a result appears
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      if (out_valid) begin
        n_tests++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL R1: out_valid=1 with no request pending, expected 0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (out_result !== e.res || out_flags !== e.flg || out_to_hl !== e.hl) begin
            n_fail++;
            $display("FAIL %s: result=%h flags=%b hl=%b, expected result=%h flags=%b hl=%b",
                     e.req, out_result, out_flags, out_to_hl, e.res, e.flg, e.hl);
          end
        end
      end else if (sb.size() != 0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R1: out_valid=0 with %0d pending, expected 1", sb.size());
        sb.delete();
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    n_tests++;
    if (out_valid !== 1'b0 || out_result !== 16'h0 || out_flags !== 4'h0 || out_to_hl !== 1'b0) begin
      n_fail++;
      $display("FAIL R8: valid=%b result=%h flags=%b hl=%b, expected all zero",
               out_valid, out_result, out_flags, out_to_hl);
    end
    rst_n = 1'b1;
    idle(2);

    // R2 pair add: half only, carry only, both, neither, zero kept
    send(3'd0, 16'h0FFF, 16'h0001, 8'h00, 4'b0000, "R2 half-only");
    send(3'd0, 16'h8000, 16'h8000, 8'h00, 4'b0101, "R2 carry-only");
    send(3'd0, 16'hFFFF, 16'h0001, 8'h00, 4'b0000, "R2 wrap zero-kept-clear");
    send(3'd0, 16'h1234, 16'h0101, 8'h00, 4'b1111, "R2 no-carry zero-kept-set");
    idle(1);
    // R3 inc/dec across boundary
    send(3'd1, 16'hFFFF, 16'h0000, 8'h00, 4'b1010, "R3 inc wrap");
    send(3'd2, 16'h0000, 16'h0000, 8'h00, 4'b0101, "R3 dec wrap");
    send(3'd1, 16'h00FF, 16'h0000, 8'h00, 4'b0011, "R3 inc byte edge");
    idle(2);
    // R4 R5 displacement forms
    send(3'd3, 16'h00FF, 16'h0000, 8'h01, 4'b1111, "R4 R5 sp+1 carries");
    send(3'd3, 16'h0000, 16'h0000, 8'hFF, 4'b1111, "R4 R5 sp-1 no low carry");
    send(3'd4, 16'hFFF8, 16'h0000, 8'h08, 4'b1100, "R4 R5 to-hl zero result");
    send(3'd4, 16'h1234, 16'h0000, 8'h80, 4'b0000, "R4 R5 to-hl -128");
    send(3'd3, 16'h100F, 16'h0000, 8'hF1, 4'b0000, "R4 R5 negative with low carry");
    idle(1);
    // R6 relative offset
    send(3'd5, 16'h0100, 16'h0000, 8'hFE, 4'b1011, "R6 back");
    send(3'd5, 16'hFFF0, 16'h0000, 8'h7F, 4'b0100, "R6 forward wrap");
    // R7 push/pop adjust
    send(3'd6, 16'h0001, 16'h0000, 8'h00, 4'b1001, "R7 push wrap");
    send(3'd7, 16'hFFFE, 16'h0000, 8'h00, 4'b0110, "R7 pop wrap");
    send(3'd6, 16'hC000, 16'h0000, 8'h00, 4'b0000, "R7 push plain");
    idle(3);

    // R1 idle cycles give no result
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: out_valid=%b while idle, expected 0", out_valid);
    end
    idle(1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule